// File: doc/BRIEF.md
# PWM Controller Fault Shutdown Sequencer

This block decides when the gate drivers of a switching power converter may run and generates the digital soft-start ramp that the pulse-width modulator follows. It watches five asynchronous flags: an enable level, a latching-shutdown request, an overcurrent comparator output and two supply comparators. One supply comparator reports that the supply is above the turn-on threshold. The other reports that it is below the turn-off threshold. Each flag passes through a two-flop synchronizer before the sequencer acts on it.

The soft-start capacitor is modelled as an up/down counter. It charges by one count every `CHG_DIV` clocks and discharges by `DIS_STEP` counts per clock, stopping at zero. A sustained overload makes the ramp cycle repeatedly: it discharges fast and then recharges slowly (hiccup). A latching shutdown holds the converter off. Toggling the enable does not release it; only a supply undervoltage event does.

Top module: `pwm_fault_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released until a supply turn-on is seen, the block reports undervoltage lockout (`uvlo_flag`=1). In this state `drv_en`=0, `ramp`=0, `ramp_done`=0, `latched_flag`=0 and `hiccup_flag`=0.
- R2: `drv_en` is 1 only while ramping or running with enable high and no synchronized fault. It falls combinationally in the cycle in which a synchronized overcurrent, latch, supply-low or low-enable value first appears, two rising edges after the input changes.
- R3: A low enable forces `ramp` to 0 one edge after the synchronized value appears. When enable is high and there is no fault, the block leaves the idle state and a new ramp starts from 0.
- R4: While ramping, `ramp` increases by exactly 1 every `CHG_DIV` clocks and never rises by any other amount.
- R5: A synchronized overcurrent sets `hiccup_flag` and lowers `ramp` by `DIS_STEP` per clock, saturating at 0.
- R6: Once `ramp` has reached 0 with no overcurrent and enable high, it recharges at the slow rate. For as long as overcurrent keeps recurring, `ramp_done` never asserts.
- R7: `ramp_done` is 1 exactly when `ramp` equals full scale (2^`RAMP_W`-1). The block then holds in the run state. Reaching full scale clears `hiccup_flag`; apart from that, only undervoltage lockout clears it.
- R8: A synchronized latching-shutdown request sets `latched_flag`, forces `ramp` to 0 and turns `drv_en` off. Toggling enable or overcurrent afterwards leaves it set.
- R9: `latched_flag` clears only when the synchronized supply-low flag enters undervoltage lockout.
- R10: A synchronized supply-low flag enters lockout with `ramp`=0. Lockout is left only when supply-ok is 1 and supply-low is 0, going first to idle and from there into a ramp from 0.
- R11: When several synchronized conditions are present in the same cycle, the priority is supply-low, then latch, then overcurrent, then enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_in | input | 1 | Converter enable level (async) |
| latch_req | input | 1 | Latching shutdown request (async) |
| oc_flag | input | 1 | Overcurrent comparator output (async) |
| supply_ok | input | 1 | Supply above turn-on threshold (async) |
| supply_low | input | 1 | Supply below turn-off threshold (async) |
| drv_en | output | 1 | Gate driver enable |
| ramp | output | RAMP_W | Soft-start ramp value |
| ramp_done | output | 1 | Ramp at full scale |
| uvlo_flag | output | 1 | Undervoltage lockout active |
| latched_flag | output | 1 | Latched off |
| hiccup_flag | output | 1 | Overcurrent recovery in progress |

## Verification
Two functions can act in the same cycle. A latching request can arrive together with an overcurrent, and a supply-low event can arrive together with either of them. An overcurrent can also land on the cycle in which the ramp reaches full scale, so completion and hiccup start compete. The bench drives such pairs on the same falling edge. It checks that only the higher-priority action is visible: the latch is set and the hiccup flag is untouched. Long random runs with biased input levels then compare every output, every cycle, against a bench-side model of the sequencing rules.

// File: rtl/pwm_fault_sequencer.sv
module pwm_fault_sequencer #(
  parameter int RAMP_W   = 10,
  parameter int CHG_DIV  = 64,
  parameter int DIS_STEP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_in,
  input  logic              latch_req,
  input  logic              oc_flag,
  input  logic              supply_ok,
  input  logic              supply_low,
  output logic              drv_en,
  output logic [RAMP_W-1:0] ramp,
  output logic              ramp_done,
  output logic              uvlo_flag,
  output logic              latched_flag,
  output logic              hiccup_flag
);
  localparam int DIV_W = (CHG_DIV > 1) ? $clog2(CHG_DIV) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(CHG_DIV - 1);
  localparam logic [RAMP_W-1:0] FULL     = {RAMP_W{1'b1}};
  localparam logic [RAMP_W-1:0] STEP     = RAMP_W'(DIS_STEP);

  typedef enum logic [2:0] {S_UVLO, S_IDLE, S_RAMP, S_RUN, S_HIC, S_LATCH} st_t;

  st_t              st;
  logic [4:0]       sy1, sy2;
  logic [DIV_W-1:0] div;
  logic             hic;

  wire en_s  = sy2[0];
  wire oc_s  = sy2[1];
  wire lat_s = sy2[2];
  wire ok_s  = sy2[3];
  wire low_s = sy2[4];

  wire [RAMP_W-1:0] ramp_dn = (ramp > STEP) ? ramp - STEP : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {supply_low, supply_ok, latch_req, oc_flag, en_in};
      sy2 <= sy1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_UVLO;
      ramp <= '0;
      div  <= '0;
      hic  <= 1'b0;
    end else if (low_s) begin
      st   <= S_UVLO;
      ramp <= '0;
      div  <= '0;
      hic  <= 1'b0;
    end else if (st == S_UVLO) begin
      if (ok_s) st <= S_IDLE;
    end else if (st == S_LATCH) begin
      st <= S_LATCH;
    end else if (lat_s) begin
      st   <= S_LATCH;
      ramp <= '0;
      div  <= '0;
    end else if (oc_s) begin
      st   <= S_HIC;
      hic  <= 1'b1;
      ramp <= ramp_dn;
      div  <= '0;
    end else if (!en_s) begin
      st   <= S_IDLE;
      ramp <= '0;
      div  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          st  <= S_RAMP;
          div <= '0;
        end
        S_HIC: begin
          if (ramp == '0) begin
            st  <= S_RAMP;
            div <= '0;
          end else begin
            ramp <= ramp_dn;
          end
        end
        S_RAMP: begin
          if (div == DIV_LAST) begin
            div  <= '0;
            ramp <= ramp + 1'b1;
            if (ramp == FULL - 1'b1) begin
              st  <= S_RUN;
              hic <= 1'b0;
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        default: st <= st;
      endcase
    end
  end

  assign drv_en       = (st == S_RAMP || st == S_RUN) && en_s && !oc_s && !lat_s && !low_s;
  assign ramp_done    = (ramp == FULL);
  assign uvlo_flag    = (st == S_UVLO);
  assign latched_flag = (st == S_LATCH);
  assign hiccup_flag  = hic;
endmodule

// File: rtl/pwm_fault_sequencer_chk.sv
module pwm_fault_sequencer_chk #(
  parameter int RAMP_W   = 10,
  parameter int DIS_STEP = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drv_en,
  input logic [RAMP_W-1:0] ramp,
  input logic              ramp_done,
  input logic              uvlo_flag,
  input logic              latched_flag,
  input logic              hiccup_flag
);
  localparam logic [RAMP_W-1:0] STEP = RAMP_W'(DIS_STEP);

  a_r2_drv_not_in_off: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (!uvlo_flag && !latched_flag));

  a_r8_latched_idle: assert property (@(posedge clk) disable iff (!rst_n)
    latched_flag |-> (ramp == '0 && !drv_en && !ramp_done));

  a_r4_charge_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp > $past(ramp)) |-> (ramp == $past(ramp) + RAMP_W'(1)));

  a_r5_discharge_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp < $past(ramp)) |-> (ramp == '0 || ramp == $past(ramp) - STEP));

  a_r9_latch_exit_uvlo: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latched_flag) |-> uvlo_flag);

  a_r7_hiccup_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hiccup_flag) |-> (ramp_done || uvlo_flag));

  a_r10_uvlo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_flag |-> (ramp == '0 && !drv_en));

  a_r5_hiccup_drv_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hiccup_flag) |-> !drv_en);
endmodule

bind pwm_fault_sequencer pwm_fault_sequencer_chk #(.RAMP_W(RAMP_W), .DIS_STEP(DIS_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .ramp(ramp), .ramp_done(ramp_done),
  .uvlo_flag(uvlo_flag), .latched_flag(latched_flag), .hiccup_flag(hiccup_flag)
);

// File: tb/tb_pwm_fault_sequencer.sv
module tb_pwm_fault_sequencer;
  localparam int W = 6, DIV = 4, STP = 5;
  localparam int FULL = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic en_in = 0, latch_req = 0, oc_flag = 0, supply_ok = 0, supply_low = 0;
  logic drv_en, ramp_done, uvlo_flag, latched_flag, hiccup_flag;
  logic [W-1:0] ramp;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0, seen_done = 0;

  pwm_fault_sequencer #(.RAMP_W(W), .CHG_DIV(DIV), .DIS_STEP(STP)) dut (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .latch_req(latch_req), .oc_flag(oc_flag),
    .supply_ok(supply_ok), .supply_low(supply_low), .drv_en(drv_en), .ramp(ramp),
    .ramp_done(ramp_done), .uvlo_flag(uvlo_flag), .latched_flag(latched_flag),
    .hiccup_flag(hiccup_flag));

  always #10 clk = ~clk;

  // reference model: 0 lockout, 1 idle, 2 ramp, 3 run, 4 hiccup, 5 latched
  int m_st = 0, m_ramp = 0, m_div = 0;
  bit m_hic = 0;
  logic [4:0] m1 = 0, m2 = 0;

  function automatic int dn(int v);
    return (v > STP) ? v - STP : 0;
  endfunction

  function automatic bit exp_drv();
    return (m_st == 2 || m_st == 3) && m2[0] && !m2[1] && !m2[2] && !m2[4];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; m_st = 0; m_ramp = 0; m_div = 0; m_hic = 0;
    end else begin
      if (m2[4]) begin m_st = 0; m_ramp = 0; m_div = 0; m_hic = 0; end
      else if (m_st == 0) begin if (m2[3]) m_st = 1; end
      else if (m_st == 5) ;
      else if (m2[2]) begin m_st = 5; m_ramp = 0; m_div = 0; end
      else if (m2[1]) begin m_st = 4; m_hic = 1; m_ramp = dn(m_ramp); m_div = 0; end
      else if (!m2[0]) begin m_st = 1; m_ramp = 0; m_div = 0; end
      else if (m_st == 1) begin m_st = 2; m_div = 0; end
      else if (m_st == 4) begin
        if (m_ramp == 0) begin m_st = 2; m_div = 0; end else m_ramp = dn(m_ramp);
      end else if (m_st == 2) begin
        if (m_div == DIV - 1) begin
          m_div = 0; m_ramp++;
          if (m_ramp == FULL) begin m_st = 3; m_hic = 0; end
        end else m_div++;
      end
      m2 = m1;
      m1 = {supply_low, supply_ok, latch_req, oc_flag, en_in};
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 drv_en", drv_en, exp_drv());
      chk("R4 ramp", ramp, m_ramp);
      chk("R7 ramp_done", ramp_done, m_ramp == FULL);
      chk("R10 uvlo_flag", uvlo_flag, m_st == 0);
      chk("R8 latched_flag", latched_flag, m_st == 5);
      chk("R6 hiccup_flag", hiccup_flag, m_hic);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    step(3);
    chk("R1 uvlo in reset", uvlo_flag, 1);
    chk("R1 drv in reset", drv_en, 0);
    chk("R1 ramp in reset", ramp, 0);
    chk("R1 latched in reset", latched_flag, 0);
    rst_n = 1;
    step(5);
    chk("R1 uvlo until turn-on", uvlo_flag, 1);

    supply_ok = 1; en_in = 1;
    step(5);
    chk("R3 drv after enable", drv_en, 1);
    chk("R3 ramp from zero", ramp, 0);
    step(FULL * DIV + 10);
    chk("R7 done after ramp", ramp_done, 1);

    en_in = 0;
    step(3);
    chk("R3 ramp cleared by enable low", ramp, 0);
    en_in = 1;
    step(FULL * DIV + 10);

    oc_flag = 1; step(1); oc_flag = 0;
    chk("R2 drv before sync", drv_en, 1);
    step(1);
    chk("R2 drv drops on sync", drv_en, 0);
    step(1);
    chk("R5 fast discharge", ramp, FULL - STP);
    chk("R5 hiccup set", hiccup_flag, 1);
    step(20);
    chk("R6 hiccup held while recharging", hiccup_flag, 1);

    oc_flag = 1;
    for (int i = 0; i < 600; i++) begin
      step(1);
      if (ramp_done) seen_done = 1;
      if (i % 40 == 30) begin oc_flag = 0; step(8); oc_flag = 1; end
    end
    chk("R6 no completion under overload", seen_done, 0);
    oc_flag = 0;
    step(FULL * DIV + 20);
    chk("R7 hiccup cleared at full", hiccup_flag, 0);

    latch_req = 1; oc_flag = 1;
    step(3);
    chk("R11 latch wins over oc", latched_flag, 1);
    chk("R11 hiccup untouched", hiccup_flag, 0);
    latch_req = 0; oc_flag = 0;
    en_in = 0; step(10); en_in = 1; step(10);
    chk("R8 latch survives enable toggle", latched_flag, 1);
    chk("R8 drv off while latched", drv_en, 0);
    latch_req = 1;
    supply_low = 1; supply_ok = 0;
    step(4);
    chk("R9 latch cleared by supply low", latched_flag, 0);
    chk("R11 uvlo wins over latch", uvlo_flag, 1);
    latch_req = 0; supply_low = 0;
    step(10);
    chk("R10 stays locked without turn-on", uvlo_flag, 1);
    supply_ok = 1;
    step(5);
    chk("R10 leaves lockout", uvlo_flag, 0);

    for (int s = 0; s < 2500; s++) begin
      en_in      = ($urandom % 100) < 85;
      oc_flag    = ($urandom % 100) < 15;
      latch_req  = ($urandom % 100) < 3;
      supply_low = ($urandom % 100) < 3;
      supply_ok  = ($urandom % 100) < 90;
      step(1 + ($urandom % 40));
      if (($urandom % 10) == 0) begin
        oc_flag = 0; latch_req = 0; supply_low = 0; supply_ok = 1; en_in = 1;
        step(FULL * DIV / 2);
      end
    end
    finish_run();
  end
endmodule